// File: doc/BRIEF.md
# Forced-Parity Serial Transmitter

This block turns bytes into asynchronous serial frames on one transmit line. Each frame carries a start bit, eight data bits, a ninth "parity-position" bit and a stop bit. The parity-position bit is not computed from the data. It is a mark (1) or space (0) value that the sender picks for each byte and hands over with it on a sideband input. This suits protocols where nearly every byte of a packet goes out with mark and one byte goes out with space.

Bytes arrive on a valid/ready handshake. An internal divider derives the bit time from the system clock frequency and the baud rate, which defaults to 9600. The link is half-duplex, so a driver-enable output turns on the line transceiver one bit time before a frame starts. It stays on across frames sent back to back and turns off when the last stop bit ends. A second byte can be taken during the stop bit of the current frame, so its start bit follows the stop bit with no idle time between them.

Top module: `fp_serial_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `drv_en` is 0 and `in_ready` is 1.
- R2: A frame is sent in this order: a start bit of 0, then `in_data` bit 0 through bit 7 (least significant first), then the parity-position bit, then a stop bit of 1.
- R3: The parity-position bit equals the `in_mark` value captured with the byte (1 = mark, 0 = space), whatever the data bits are.
- R4: The mark/space choice is made per byte: consecutive frames may carry different parity-position values with no reconfiguration.
- R5: Data and mark/space are captured at the cycle where `in_valid` and `in_ready` are both 1. Later changes on `in_data`, `in_mark`, or `in_valid` while low, do not alter or start a frame.
- R6: After a byte is accepted from idle, `drv_en` rises on the next clock edge, and `txd` stays 1 for exactly one bit time before the start bit.
- R7: `drv_en` stays 1 through every bit of a frame and falls at the end of the stop bit when no further byte has been accepted.
- R8: A byte accepted during the stop bit of a frame has its start bit begin immediately after that stop bit, and `drv_en` stays 1 between the two frames.
- R9: `in_ready` is 0 from acceptance until the stop bit of the current frame begins, and stays 0 once a follow-on byte is held.
- R10: Each bit, including the lead time before the start bit, lasts CLK_HZ/BAUD clock cycles (integer division).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block takes the offered byte this cycle |
| in_data | input | DATA_W | Byte to send |
| in_mark | input | 1 | Parity-position value for this byte: 1 mark, 0 space |
| txd | output | 1 | Serial output line, idles high |
| drv_en | output | 1 | Half-duplex transceiver drive enable |

## Verification
The bench builds the block with CLK_HZ = 80 and BAUD = 10, so each bit lasts eight clocks. At that rate a full frame takes under a hundred cycles. Single frames, chains of back-to-back frames and idle gaps all fit in a short run, and mid-bit sampling lands on an exact cycle. An off-by-one in the divider therefore drifts past half a bit within one frame and shows up as a wrong bit. The default divider of 10416 would make each frame cost over a hundred thousand cycles.

// File: rtl/fp_tx_pkg.sv
package fp_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_SEND = 2'd2
  } tx_state_e;

  // start + data + parity position + stop
  function automatic int unsigned frame_bits(input int unsigned data_w);
    return data_w + 3;
  endfunction

endpackage

// File: rtl/fp_bit_timer.sv
module fp_bit_timer #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic bit_end
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  // Held at zero while idle so the first bit time starts at acceptance.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign bit_end = run && (cnt == LAST);

endmodule

// File: rtl/fp_frame_shift.sv
module fp_frame_shift
  import fp_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_mark,
  output logic              txd
);
  localparam int unsigned FW = frame_bits(DATA_W);

  logic [FW-1:0] sh;

  // Whole frame preloaded; ones shift in from the top so the line idles high.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh <= '1;
    end else if (load) begin
      sh <= {1'b1, ld_mark, ld_data, 1'b0};
    end else if (shift) begin
      sh <= {1'b1, sh[FW-1:1]};
    end
  end

  assign txd = sh[0];

endmodule

// File: rtl/fp_tx_seq.sv
module fp_tx_seq
  import fp_tx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mark,
  input  logic              bit_end,
  output logic              in_ready,
  output logic              run,
  output logic              load,
  output logic              shift,
  output logic [DATA_W-1:0] ld_data,
  output logic              ld_mark,
  output logic              drv_en
);
  localparam int unsigned FW = frame_bits(DATA_W);
  localparam int unsigned IW = $clog2(FW);
  localparam logic [IW-1:0] STOP_IDX = IW'(FW - 1);

  tx_state_e         state;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] hold_data;
  logic              hold_mark;
  logic              hold_v;

  logic on_stop;
  logic fire;
  logic have_next;

  assign on_stop   = (state == ST_SEND) && (idx == STOP_IDX);
  assign in_ready  = (state == ST_IDLE) || (on_stop && !hold_v);
  assign fire      = in_valid && in_ready;
  assign have_next = hold_v || fire;
  assign run       = (state != ST_IDLE);

  // A byte taken in the last stop cycle bypasses the holding slot.
  assign ld_data = hold_v ? hold_data : in_data;
  assign ld_mark = hold_v ? hold_mark : in_mark;

  assign load  = bit_end && ((state == ST_LEAD) || (on_stop && have_next));
  assign shift = bit_end && (state == ST_SEND) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_mark <= 1'b0;
      hold_v    <= 1'b0;
    end else if (fire && !load) begin
      hold_data <= in_data;
      hold_mark <= in_mark;
      hold_v    <= 1'b1;
    end else if (load) begin
      hold_v    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      idx    <= '0;
      drv_en <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fire) begin
            state  <= ST_LEAD;
            drv_en <= 1'b1;
          end
        end
        ST_LEAD: begin
          if (bit_end) begin
            state <= ST_SEND;
            idx   <= '0;
          end
        end
        ST_SEND: begin
          if (bit_end) begin
            if (on_stop) begin
              idx <= '0;
              if (!have_next) begin
                state  <= ST_IDLE;
                drv_en <= 1'b0;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        default: begin
          state  <= ST_IDLE;
          drv_en <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/fp_serial_tx.sv
module fp_serial_tx
  import fp_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned BAUD   = 9600,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mark,
  output logic              txd,
  output logic              drv_en
);
  localparam int unsigned DIV = (CLK_HZ / BAUD > 0) ? CLK_HZ / BAUD : 1;

  logic              run;
  logic              bit_end;
  logic              load;
  logic              shift;
  logic [DATA_W-1:0] ld_data;
  logic              ld_mark;

  fp_bit_timer #(.DIV(DIV)) i_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .bit_end (bit_end)
  );

  fp_tx_seq #(.DATA_W(DATA_W)) i_seq (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_mark  (in_mark),
    .bit_end  (bit_end),
    .in_ready (in_ready),
    .run      (run),
    .load     (load),
    .shift    (shift),
    .ld_data  (ld_data),
    .ld_mark  (ld_mark),
    .drv_en   (drv_en)
  );

  fp_frame_shift #(.DATA_W(DATA_W)) i_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .shift   (shift),
    .ld_data (ld_data),
    .ld_mark (ld_mark),
    .txd     (txd)
  );

endmodule

// File: rtl/fp_serial_tx_chk.sv
module fp_serial_tx_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic drv_en
);
  // R1: line high whenever the driver is off
  a_r1_quiet_line: assert property (@(posedge clk) disable iff (rst)
    !drv_en |-> txd);

  // R2: a start edge only happens with the driver on
  a_r2_start_driven: assert property (@(posedge clk) disable iff (rst)
    $fell(txd) |-> drv_en);

  // R6: the lead bit time begins with the line high
  a_r6_lead_high: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_en) |-> txd);

  // R9: no acceptance during a start bit
  a_r9_busy_start: assert property (@(posedge clk) disable iff (rst)
    (drv_en && !txd) |-> !in_ready);

  // R5: each acceptance closes the slot for the following cycle
  a_r5_take_once: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  // R7: releasing the driver leaves the block ready
  a_r7_release_ready: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_en) |-> in_ready);

endmodule

bind fp_serial_tx fp_serial_tx_chk i_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .txd      (txd),
  .drv_en   (drv_en)
);

// File: tb/test_fp_serial_tx.sv
`timescale 1ns/1ps
module test_fp_serial_tx;
  localparam int CLK_HZ = 80;
  localparam int BAUD   = 10;
  localparam int DW     = 8;
  localparam int DIV    = CLK_HZ / BAUD;   // R10: clocks per bit

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_mark = 1'b0;
  logic          txd;
  logic          drv_en;

  always #2.5 clk = ~clk;

  fp_serial_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(DW)) i_fp_serial_tx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_mark(in_mark), .txd(txd), .drv_en(drv_en)
  );

  typedef struct {
    logic [DW-1:0] d;
    logic          m;
    bit            chained;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: offers a byte, records the expected frame, then scrambles inputs (R5)
  task automatic send(input logic [DW-1:0] d, input logic m);
    exp_t e;
    @(negedge clk);
    in_data = d; in_mark = m; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    e.d = d; e.m = m; e.chained = drv_en;
    q.push_back(e);
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_data = ~d; in_mark = ~m;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (drv_en || q.size() != 0) @(negedge clk);
    repeat (2 * DIV) @(negedge clk);
  endtask

  // Monitor: decodes each frame at mid-bit and compares with the queue
  task automatic decode(input bit chained);
    exp_t e;
    logic [DW+2:0] bits;
    bit have;
    have = (q.size() != 0);
    chk(have, "R2", "frame without pending byte", 1, 0);
    if (have) e = q.pop_front();
    chk(txd == 1'b0, "R10", "start bit at one bit time boundary", txd, 0);
    repeat (DIV / 2) @(negedge clk);
    bits[0] = txd;
    for (int k = 1; k <= DW + 2; k++) begin
      repeat (DIV) @(negedge clk);
      bits[k] = txd;
      chk(drv_en == 1'b1, "R7", "drv_en inside frame", drv_en, 1);
    end
    repeat (DIV - DIV / 2) @(negedge clk);
    chk(bits[0] == 1'b0, "R2", "start bit", bits[0], 0);
    chk(bits[DW+2] == 1'b1, "R2", "stop bit", bits[DW+2], 1);
    if (have) begin
      chk(bits[DW:1] == e.d, "R2", "data LSB first", bits[DW:1], e.d);
      chk(bits[DW+1] == e.m, "R3", "parity position", bits[DW+1], e.m);
      chk(chained == e.chained, "R8", "chained start", chained, e.chained);
    end
  endtask

  initial begin : monitor
    bit more;
    bit chained;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      if (drv_en) begin
        chk(txd == 1'b1, "R6", "lead cycle line", txd, 1);
        for (int i = 1; i < DIV; i++) begin
          @(negedge clk);
          chk(txd == 1'b1 && drv_en == 1'b1, "R6", "lead line and enable",
              {txd, drv_en}, 2'b11);
        end
        @(negedge clk);
        chained = 1'b0;
        do begin
          decode(chained);
          if (drv_en) begin
            chk(txd == 1'b0, "R8", "next start right after stop", txd, 0);
            chained = 1'b1;
            more = 1'b1;
          end else begin
            chk(txd == 1'b1, "R7", "line released after stop", txd, 1);
            more = 1'b0;
          end
        end while (more);
      end
    end
  end

  task automatic run_tests();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1,     "R1", "txd after reset", txd, 1);
    chk(drv_en == 1'b0,  "R1", "drv_en after reset", drv_en, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);

    // R5: changing inputs with valid low starts nothing
    for (int i = 0; i < 3 * DIV; i++) begin
      @(negedge clk);
      in_data = DW'(i * 37); in_mark = i[0];
    end
    chk(drv_en == 1'b0 && txd == 1'b1, "R5", "no frame without valid",
        {drv_en, txd}, 2'b01);

    // Single frames: R2, R3, R6, R7
    send(8'hA5, 1'b1);
    wait_idle();
    send(8'h3C, 1'b0);
    // R9: busy mid-frame
    repeat (3 * DIV) @(negedge clk);
    chk(in_ready == 1'b0, "R9", "ready low mid-frame", in_ready, 0);
    wait_idle();
    chk(in_ready == 1'b1 && drv_en == 1'b0, "R1", "idle after frame",
        {in_ready, drv_en}, 2'b10);

    // Back-to-back with per-byte mark/space switching: R4, R8
    send(8'h00, 1'b1);
    send(8'h01, 1'b1);
    send(8'hFF, 1'b0);
    send(8'h7E, 1'b1);
    send(8'h80, 1'b0);
    wait_idle();

    // Same data, opposite parity choices: R3 independence from data
    send(8'h55, 1'b0);
    send(8'h55, 1'b1);
    wait_idle();
    chk(q.size() == 0, "R8", "all expected frames seen", q.size(), 0);
  endtask

  initial begin : main
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule